// File: doc/BRIEF.md
# DMA-Filled Transmit Byte Buffer

This block holds outgoing bytes between an external DMA engine and a local processor that feeds a serial transmitter. The processor arms a transfer by writing a byte count of 1 to 18. The block then goes busy and raises its DMA request. It takes one 16-bit word for each accepted bus strobe while the active-low grant is held low, and it keeps count of how many words are still owed.

When the last word lands, the request and the busy flag drop together. An optional single-cycle interrupt marks the moment. The processor then pulls bytes out one per read strobe, low byte of each word first, starting at the first word written. For an odd count the upper byte of the final word never appears. The grant may be withdrawn part-way through a fill, and the block simply waits until it returns. Two mode inputs change the handshake. One swaps the meaning of the two bus strobes for fly-by transfers. The other makes the request fall for a cycle after each word, so that every transfer is started by a fresh rising edge.

Top module: `tx_mailbox`

## Requirements
- R1: A synchronous reset, whether at start-up or in the middle of a fill, leaves `busy`, `dreq`, `irq` and `drain_valid` low on the next cycle.
- R2: While idle, a `cfg_wr` pulse with `cfg_bytes` from 1 to 18 raises `busy` and `dreq` on the next cycle and arms ceil(`cfg_bytes`/2) word transfers.
- R3: A `cfg_wr` with a count of 0 or above 18 is ignored. A `cfg_wr` while `busy` is high is also ignored, and this includes the cycle of the final word store. The armed byte count is then unchanged.
- R4: A word is stored in a cycle where `busy` is high, `dack_n` is low and the store strobe is low. Each store reduces the remaining count by one, and words land in ascending order.
- R5: While `dack_n` is high, nothing is stored and `dreq` and `busy` stay high in level mode. The fill resumes when `dack_n` returns low.
- R6: The store of the last owed word drops `busy` and `dreq` on the next cycle. In that same cycle `irq` is a one-cycle pulse, but only if `int_en` was high.
- R7: With `fly_by` low, `bus_wr_n` is the store strobe and `bus_rd_n` is ignored. With `fly_by` high, `bus_rd_n` stores. A low `bus_wr_n` with `dack_n` low raises `bus_oe` and drives `bus_dout` with the word that holds the next byte to drain.
- R8: With `pulse_mode` high, `dreq` is low for the one cycle after each non-final store, and no store is taken in that cycle.
- R9: Once idle, `drain_valid` is high while bytes remain. `drain_byte` gives byte k of the transfer: byte k is bits [7:0] of word k/2 for even k and bits [15:8] for odd k. Each `drain_rd` advances by one byte. After exactly `cfg_bytes` reads `drain_valid` falls, and further `drain_rd` pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Processor write strobe for the byte count |
| cfg_bytes | input | 5 | Byte count for the next transfer |
| int_en | input | 1 | Enables the end-of-fill interrupt |
| fly_by | input | 1 | Swaps the roles of the bus strobes |
| pulse_mode | input | 1 | Selects the edge-per-transfer request mode |
| busy | output | 1 | Status bit: fill in progress |
| irq | output | 1 | One-cycle end-of-fill interrupt |
| dreq | output | 1 | DMA request |
| dack_n | input | 1 | DMA grant, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_din | input | 16 | Word written by the DMA |
| bus_dout | output | 16 | Word driven out during a fly-by write strobe |
| bus_oe | output | 1 | High while bus_dout is driven |
| drain_rd | input | 1 | Processor byte read strobe |
| drain_byte | output | 8 | Byte at the drain position |
| drain_valid | output | 1 | Bytes remain to be drained |

## Verification
A processor count write can arrive in the same cycle as the DMA store of the final word. At that edge `busy` is still high, so the write has to be dropped, even though `busy` reads low one cycle later. The bench provokes this by raising `cfg_wr` with a new count together with the last store. It then judges the outcome by the drain: the drain must return exactly the old byte count and then go invalid. It also checks that `busy` stays low until a second count write is made on its own.

// File: rtl/tx_mailbox.sv
module tx_mailbox #(
  parameter int WORDS = 9,
  parameter int BYTE  = 8,
  parameter int CW    = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_wr,
  input  logic [CW-1:0]   cfg_bytes,
  input  logic            int_en,
  input  logic            fly_by,
  input  logic            pulse_mode,
  output logic            busy,
  output logic            irq,
  output logic            dreq,
  input  logic            dack_n,
  input  logic            bus_wr_n,
  input  logic            bus_rd_n,
  input  logic [2*BYTE-1:0] bus_din,
  output logic [2*BYTE-1:0] bus_dout,
  output logic            bus_oe,
  input  logic            drain_rd,
  output logic [BYTE-1:0] drain_byte,
  output logic            drain_valid
);
  localparam int DW    = 2 * BYTE;
  localparam int BYTES = 2 * WORDS;
  localparam int PW    = $clog2(WORDS);

  logic [DW-1:0] mem [WORDS];
  logic [CW-1:0] total_q, left_q, rd_q;
  logic [PW-1:0] wr_q, ridx;
  logic          busy_q, gap_q, irq_q;
  logic [CW:0]   wsum;

  wire strobe_n = fly_by ? bus_rd_n : bus_wr_n;
  wire count_ok = (cfg_bytes != '0) && (cfg_bytes <= CW'(BYTES));
  wire load     = cfg_wr && !busy_q && count_ok;
  wire store    = busy_q && !gap_q && !dack_n && !strobe_n;
  wire last     = store && (left_q == CW'(1));
  wire take     = drain_rd && drain_valid;

  assign wsum = {1'b0, cfg_bytes} + (CW+1)'(1);
  assign ridx = ((rd_q >> 1) < CW'(WORDS)) ? PW'(rd_q >> 1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      left_q  <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      busy_q  <= 1'b0;
      gap_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      gap_q <= 1'b0;
      if (load) begin
        total_q <= cfg_bytes;
        left_q  <= wsum[CW:1];
        rd_q    <= '0;
        wr_q    <= '0;
        busy_q  <= 1'b1;
      end else begin
        if (store) begin
          wr_q   <= wr_q + PW'(1);
          left_q <= left_q - CW'(1);
          gap_q  <= pulse_mode && !last;
          if (last) begin
            busy_q <= 1'b0;
            irq_q  <= int_en;
          end
        end
        if (take) rd_q <= rd_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store) mem[wr_q] <= bus_din;
  end

  assign busy        = busy_q;
  assign irq         = irq_q;
  assign dreq        = busy_q && !gap_q;
  assign drain_valid = !busy_q && (rd_q < total_q);
  assign drain_byte  = rd_q[0] ? mem[ridx][DW-1:BYTE] : mem[ridx][BYTE-1:0];
  assign bus_dout    = mem[ridx];
  assign bus_oe      = fly_by && !dack_n && !bus_wr_n;

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy_q && !dreq && !irq_q && !drain_valid);
  a_r3_busy_cfg_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && busy_q) |=> $stable(total_q));
  a_r4_store_counts: assert property (@(posedge clk) disable iff (rst)
    (store && !last) |=> (left_q == $past(left_q) - CW'(1)) && busy_q);
  a_r5_pause_holds: assert property (@(posedge clk) disable iff (rst)
    (busy_q && dack_n && !gap_q) |=> busy_q && $stable(left_q) && $stable(wr_q));
  a_r6_irq_on_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (irq_q == $past(int_en)) && !dreq);
  a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_q |=> !irq_q);
  a_r8_pulse_gap: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && store && !last) |=> !dreq);
  a_r9_drain_bound: assert property (@(posedge clk) disable iff (rst)
    rd_q <= total_q);
endmodule

// File: tb/sim_tx_mailbox.sv
module sim_tx_mailbox;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [4:0] cfg_bytes = '0;
  logic int_en = 1'b0, fly_by = 1'b0, pulse_mode = 1'b0;
  logic dack_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
  logic [15:0] bus_din = '0;
  logic drain_rd = 1'b0;
  logic busy, irq, dreq, bus_oe, drain_valid;
  logic [15:0] bus_dout;
  logic [7:0] drain_byte;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  tx_mailbox u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_bytes(cfg_bytes),
    .int_en(int_en), .fly_by(fly_by), .pulse_mode(pulse_mode),
    .busy(busy), .irq(irq), .dreq(dreq), .dack_n(dack_n),
    .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_oe(bus_oe), .drain_rd(drain_rd),
    .drain_byte(drain_byte), .drain_valid(drain_valid)
  );

  // {count[4:0], int_en, fly_by, pulse_mode}
  localparam logic [7:0] VEC [6] = '{
    {5'd18, 3'b100}, {5'd1, 3'b000}, {5'd7, 3'b111},
    {5'd4, 3'b010}, {5'd9, 3'b001}, {5'd2, 3'b110}
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  task automatic load(input logic [4:0] n);
    cfg_wr = 1'b1;
    cfg_bytes = n;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic feed(input logic [15:0] d);
    while (!dreq) step();
    dack_n = 1'b0;
    if (fly_by) bus_rd_n = 1'b0; else bus_wr_n = 1'b0;
    bus_din = d;
    step();
    dack_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
  endtask

  function automatic logic [15:0] wordv(input int base, input int w);
    return {8'(base + 2*w + 1), 8'(base + 2*w)};
  endfunction

  task automatic drain_all(input int n, input int base, input string req);
    for (int b = 0; b < n; b++) begin
      chk(drain_valid == 1'b1, req, drain_valid, 1);
      chk(drain_byte == 8'(base + b), req, drain_byte, 8'(base + b));
      drain_rd = 1'b1;
      step();
      drain_rd = 1'b0;
    end
    chk(drain_valid == 1'b0, req, drain_valid, 0);
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    // R1 start-up state
    chk(!busy && !dreq && !irq && !drain_valid, "R1", {busy, dreq, irq, drain_valid}, 0);

    // table walk: R2 R4 R6 R8 R9
    for (int i = 0; i < 6; i++) begin
      int n = int'(VEC[i][7:3]);
      int nw = (n + 1) / 2;
      int base = i * 40;
      int_en = VEC[i][2]; fly_by = VEC[i][1]; pulse_mode = VEC[i][0];
      load(5'(n));
      chk(busy && dreq, "R2", {busy, dreq}, 3);
      for (int w = 0; w < nw; w++) begin
        feed(wordv(base, w));
        if (w < nw - 1) begin
          chk(busy == 1'b1, "R4", busy, 1);
          chk(dreq == !pulse_mode, "R8", dreq, !pulse_mode);
        end
      end
      chk(!busy && !dreq, "R6", {busy, dreq}, 0);
      chk(irq == int_en, "R6", irq, int_en);
      step();
      chk(irq == 1'b0, "R6", irq, 0);
      drain_all(n, base, "R9");
      drain_rd = 1'b1; step(); drain_rd = 1'b0;
      chk(drain_valid == 1'b0, "R9", drain_valid, 0);
    end
    int_en = 1'b0; fly_by = 1'b0; pulse_mode = 1'b0;

    // R3 bad counts and write while busy
    load(5'd0);
    chk(busy == 1'b0, "R3", busy, 0);
    load(5'd19);
    chk(busy == 1'b0, "R3", busy, 0);
    load(5'd4);
    load(5'd10);
    feed(wordv(100, 0));
    feed(wordv(100, 1));
    chk(busy == 1'b0, "R3", busy, 0);
    drain_all(4, 100, "R3");

    // R5 grant withdrawn mid-fill
    load(5'd6);
    feed(wordv(150, 0));
    bus_wr_n = 1'b0; bus_din = 16'hDEAD;
    step(); step(); step();
    chk(busy && dreq, "R5", {busy, dreq}, 3);
    bus_wr_n = 1'b1;
    feed(wordv(150, 1));
    chk(busy == 1'b1, "R5", busy, 1);
    feed(wordv(150, 2));
    chk(busy == 1'b0, "R5", busy, 0);
    drain_all(6, 150, "R5");

    // R7 strobe roles
    load(5'd4);
    dack_n = 1'b0; bus_rd_n = 1'b0; bus_din = 16'hBEEF;
    step(); step();
    chk(busy == 1'b1, "R7", busy, 1);
    chk(bus_oe == 1'b0, "R7", bus_oe, 0);
    dack_n = 1'b1; bus_rd_n = 1'b1;
    fly_by = 1'b1;
    dack_n = 1'b0; bus_wr_n = 1'b0;
    step(); step();
    chk(busy == 1'b1, "R7", busy, 1);
    dack_n = 1'b1; bus_wr_n = 1'b1;
    feed(wordv(200, 0));
    feed(wordv(200, 1));
    chk(busy == 1'b0, "R7", busy, 0);
    dack_n = 1'b0; bus_wr_n = 1'b0;
    #1;
    chk(bus_oe == 1'b1, "R7", bus_oe, 1);
    chk(bus_dout == wordv(200, 0), "R7", bus_dout, wordv(200, 0));
    dack_n = 1'b1; bus_wr_n = 1'b1;
    drain_rd = 1'b1; step(); step(); drain_rd = 1'b0;
    dack_n = 1'b0; bus_wr_n = 1'b0;
    #1;
    chk(bus_dout == wordv(200, 1), "R7", bus_dout, wordv(200, 1));
    dack_n = 1'b1; bus_wr_n = 1'b1;
    fly_by = 1'b0;
    step();

    // R3 count write in the same cycle as the final store
    load(5'd2);
    cfg_wr = 1'b1; cfg_bytes = 5'd4;
    dack_n = 1'b0; bus_wr_n = 1'b0; bus_din = wordv(60, 0);
    step();
    cfg_wr = 1'b0; dack_n = 1'b1; bus_wr_n = 1'b1;
    chk(busy == 1'b0, "R3", busy, 0);
    step();
    chk(busy == 1'b0, "R3", busy, 0);
    drain_all(2, 60, "R3");
    load(5'd4);
    chk(busy == 1'b1, "R2", busy, 1);

    // R1 reset in the middle of a fill
    feed(wordv(10, 0));
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk(!busy && !dreq && !irq && !drain_valid, "R1", {busy, dreq, irq, drain_valid}, 0);

    report();
    $finish;
  end
endmodule